// File: doc/BRIEF.md
# Speculative Line Forwarding Matcher

This block decides whether a new speculative load can take its cache line from an older load that already fetched the same line speculatively. That older copy was fetched without becoming visible in the cache. The block keeps a small status table that mirrors the load queue. Each slot records whether its address is known, whether it has executed, whether it still owes a post-fetch, whether it was squashed or faulted, whether each half of a line-crossing access hit in L1, the line address of each half, and a stale bit for each half.

A lookup presents the requesting slot and its address. The block walks the circular window from the head pointer up to, but not including, the tail pointer. It returns the first older slot that can serve the line. If an older slot shows that the line is already in L1, the lookup misses.

An invalidate port marks matching halves stale. A store or a completed expose to a line drives this port, so data held for that line can no longer be used for forwarding. Slot state is written through one write port. A write flagged as an allocation starts the slot clean.

Top module: `sb_fwd_match`

## Requirements
- R1: After reset every slot is empty (no flag set, no stale bit), and lk_done and lk_hit are 0.
- R2: A lookup strobed on lk_req in one cycle gives lk_done=1 with lk_hit and lk_src in the next cycle only. lk_hit is 0 whenever lk_done is 0.
- R3: Addresses are compared at cache-line granularity: the low log2(LINE_BYTES) bits of the request, written and invalidate addresses are ignored.
- R4: Only slots in the circular window [head, tail) with the address-valid flag set take part. head equal to tail is an empty window.
- R5: A slot can be a source only if it is executed, still needs a post-fetch, is not squashed and has no fault. The write status bits are: bit0 address valid, bit1 executed, bit2 needs post-fetch, bit3 squashed, bit4 fault, bit5 low half hit L1, bit6 high half hit L1.
- R6: A low-half match also needs the low half not to have hit L1 and not to be stale. A high-half match needs the same for the high half and a nonzero high line address.
- R7: When the scan meets a slot whose half matches the request line and that half hit L1, the lookup ends with no hit, even if a younger slot qualifies.
- R8: Among qualifying slots, the one nearest the head in circular order is returned, including across index wrap.
- R9: An invalidate marks every address-valid slot whose low line matches as low-stale. If the low line does not match but the high line does, the slot is marked high-stale. Slots without a valid address are not changed.
- R10: A lookup from a slot that is already executed returns no hit.
- R11: A write with wr_alloc=1 clears both stale bits and both L1-hit flags of the slot. A write with wr_alloc=0 keeps the stale bits. A write takes precedence over an invalidate in the same cycle for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_i | input | PW | Oldest slot of the load queue |
| tail_i | input | PW | First free slot after the youngest load |
| wr_en | input | 1 | Write slot state |
| wr_alloc | input | 1 | Write is a fresh allocation |
| wr_idx | input | PW | Slot written |
| wr_status | input | 7 | Status flags, bit layout in R5 |
| wr_addr_lo | input | ADDR_W | Address of the low half |
| wr_addr_hi | input | ADDR_W | Address of the high half (0 when not line-crossing) |
| inv_en | input | 1 | Invalidate strobe |
| inv_addr | input | ADDR_W | Address of the invalidated line |
| lk_req | input | 1 | Lookup strobe |
| lk_slot | input | PW | Requesting slot |
| lk_addr | input | ADDR_W | Address looked up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An older slot can serve the line |
| lk_src | output | PW | Source slot when lk_hit is 1 |

## Verification
The result of every lookup is due exactly one clock after the strobe. Writes and invalidates change the table at the edge on which they are presented, so they affect a lookup strobed one cycle later. A behavioural model in the bench applies the same edge rules and predicts lk_done, lk_hit and lk_src for each cycle. The outputs are compared with that prediction at every falling edge, where every register has settled. Each comparison carries the tag of the requirement the running scenario targets.

// File: rtl/sbfm_pkg.sv
package sbfm_pkg;
  // bit0 is vld, bit6 is l1hi (packed: first field is MSB)
  typedef struct packed {
    logic l1hi;
    logic l1lo;
    logic fault;
    logic squash;
    logic npf;
    logic exec;
    logic vld;
  } sbfm_flags_t;

  localparam int unsigned FLAG_W = 7;
endpackage

// File: rtl/sbfm_table.sv
module sbfm_table
  import sbfm_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 6,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [PW-1:0]     wr_idx,
  input  sbfm_flags_t       wr_flags,
  input  logic [ADDR_W-1:0] wr_line_lo,
  input  logic [ADDR_W-1:0] wr_line_hi,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_line,
  output sbfm_flags_t       flags   [DEPTH],
  output logic [ADDR_W-1:0] line_lo [DEPTH],
  output logic [ADDR_W-1:0] line_hi [DEPTH],
  output logic [DEPTH-1:0]  st_lo,
  output logic [DEPTH-1:0]  st_hi
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    sbfm_flags_t       flags_d;
    logic [ADDR_W-1:0] lo_d, hi_d;
    logic              stlo_d, sthi_d, en_d;
    logic              sel, lo_m, hi_m;

    assign sel  = wr_en && (wr_idx == PW'(i));
    assign lo_m = inv_en && flags[i].vld && (line_lo[i] == inv_line);
    assign hi_m = inv_en && flags[i].vld && (line_hi[i] == inv_line);

    always_comb begin
      flags_d = flags[i];
      lo_d    = line_lo[i];
      hi_d    = line_hi[i];
      stlo_d  = st_lo[i];
      sthi_d  = st_hi[i];
      en_d    = 1'b0;
      if (sel) begin
        en_d    = 1'b1;
        flags_d = wr_flags;
        lo_d    = wr_line_lo;
        hi_d    = wr_line_hi;
        if (wr_alloc) begin
          flags_d.l1lo = 1'b0;
          flags_d.l1hi = 1'b0;
          stlo_d       = 1'b0;
          sthi_d       = 1'b0;
        end
      end else if (lo_m) begin
        en_d   = 1'b1;
        stlo_d = 1'b1;
      end else if (hi_m) begin
        en_d   = 1'b1;
        sthi_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i]   <= '0;
        line_lo[i] <= '0;
        line_hi[i] <= '0;
        st_lo[i]   <= 1'b0;
        st_hi[i]   <= 1'b0;
      end else if (en_d) begin
        flags[i]   <= flags_d;
        line_lo[i] <= lo_d;
        line_hi[i] <= hi_d;
        st_lo[i]   <= stlo_d;
        st_hi[i]   <= sthi_d;
      end
    end
  end

endmodule

// File: rtl/sbfm_scan.sv
module sbfm_scan
  import sbfm_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  sbfm_flags_t       flags   [DEPTH],
  input  logic [ADDR_W-1:0] line_lo [DEPTH],
  input  logic [ADDR_W-1:0] line_hi [DEPTH],
  input  logic [DEPTH-1:0]  st_lo,
  input  logic [DEPTH-1:0]  st_hi,
  input  logic [PW-1:0]     head,
  input  logic [PW-1:0]     tail,
  input  logic [ADDR_W-1:0] req_line,
  input  logic              req_exec,
  output logic              hit,
  output logic [PW-1:0]     src
);

  logic [DEPTH-1:0] blk, qual;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic m_lo, m_hi, ok;
    assign m_lo = flags[i].vld && (line_lo[i] == req_line);
    assign m_hi = flags[i].vld && (line_hi[i] == req_line);
    assign ok   = flags[i].exec && flags[i].npf && !flags[i].squash && !flags[i].fault;
    assign blk[i]  = (m_lo && flags[i].l1lo) || (m_hi && flags[i].l1hi);
    assign qual[i] = ok && ((m_lo && !st_lo[i]) ||
                            (m_hi && !st_hi[i] && (line_hi[i] != '0)));
  end

  logic [PW-1:0] cnt;
  assign cnt = tail - head;

  always_comb begin
    logic          stop;
    logic [PW-1:0] idx;
    hit  = 1'b0;
    src  = '0;
    stop = req_exec;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + k[PW-1:0];
      if (!stop && (k < int'(cnt))) begin
        if (blk[idx]) begin
          stop = 1'b1;
        end else if (qual[idx]) begin
          stop = 1'b1;
          hit  = 1'b1;
          src  = idx;
        end
      end
    end
  end

endmodule

// File: rtl/sb_fwd_match.sv
module sb_fwd_match
  import sbfm_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned PW        = $clog2(DEPTH),
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     head_i,
  input  logic [PW-1:0]     tail_i,
  input  logic              wr_en,
  input  logic              wr_alloc,
  input  logic [PW-1:0]     wr_idx,
  input  logic [6:0]        wr_status,
  input  logic [ADDR_W-1:0] wr_addr_lo,
  input  logic [ADDR_W-1:0] wr_addr_hi,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              lk_req,
  input  logic [PW-1:0]     lk_slot,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [PW-1:0]     lk_src
);

  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  sbfm_flags_t       flags   [DEPTH];
  logic [ADDR_W-1:0] line_lo [DEPTH];
  logic [ADDR_W-1:0] line_hi [DEPTH];
  logic [DEPTH-1:0]  ent_stlo, ent_sthi, ent_exec;
  logic              scan_hit;
  logic [PW-1:0]     scan_src;

  for (genvar i = 0; i < DEPTH; i++) begin : g_exec
    assign ent_exec[i] = flags[i].exec;
  end

  sbfm_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_alloc   (wr_alloc),
    .wr_idx     (wr_idx),
    .wr_flags   (sbfm_flags_t'(wr_status)),
    .wr_line_lo (wr_addr_lo & LINE_MASK),
    .wr_line_hi (wr_addr_hi & LINE_MASK),
    .inv_en     (inv_en),
    .inv_line   (inv_addr & LINE_MASK),
    .flags      (flags),
    .line_lo    (line_lo),
    .line_hi    (line_hi),
    .st_lo      (ent_stlo),
    .st_hi      (ent_sthi)
  );

  sbfm_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_scan (
    .flags    (flags),
    .line_lo  (line_lo),
    .line_hi  (line_hi),
    .st_lo    (ent_stlo),
    .st_hi    (ent_sthi),
    .head     (head_i),
    .tail     (tail_i),
    .req_line (lk_addr & LINE_MASK),
    .req_exec (ent_exec[lk_slot]),
    .hit      (scan_hit),
    .src      (scan_src)
  );

  logic          done_d, hit_d;
  logic [PW-1:0] src_d;

  always_comb begin
    done_d = lk_req;
    hit_d  = lk_req && scan_hit;
    src_d  = lk_req ? scan_src : lk_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_src  <= '0;
    end else begin
      lk_done <= done_d;
      lk_hit  <= hit_d;
      lk_src  <= src_d;
    end
  end

endmodule

// File: rtl/sb_fwd_match_chk.sv
module sb_fwd_match_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PW-1:0]    head_i,
  input logic [PW-1:0]    tail_i,
  input logic             inv_en,
  input logic             lk_req,
  input logic [PW-1:0]    lk_slot,
  input logic             lk_done,
  input logic             lk_hit,
  input logic [PW-1:0]    lk_src,
  input logic [DEPTH-1:0] ent_exec,
  input logic [DEPTH-1:0] ent_stlo
);

  logic [DEPTH-1:0] src_oh;
  assign src_oh = DEPTH'(1) << lk_src;

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_done && !lk_hit));
  assert_empty_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && (head_i == tail_i)) |=> !lk_hit);
  assert_src_executed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> |($past(ent_exec) & src_oh));
  assert_stale_needs_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ent_stlo & ~$past(ent_stlo))) |-> $past(inv_en));
  assert_not_self_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_src != $past(lk_slot)));

endmodule

bind sb_fwd_match sb_fwd_match_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .head_i   (head_i),
  .tail_i   (tail_i),
  .inv_en   (inv_en),
  .lk_req   (lk_req),
  .lk_slot  (lk_slot),
  .lk_done  (lk_done),
  .lk_hit   (lk_hit),
  .lk_src   (lk_src),
  .ent_exec (ent_exec),
  .ent_stlo (ent_stlo)
);

// File: tb/sb_fwd_match_test.sv
`timescale 1ns/1ps
module sb_fwd_match_test;
  localparam int DEPTH = 8;
  localparam int PW    = 3;
  localparam int AW    = 32;
  localparam int LB    = 64;
  // status bits per R5
  localparam int V = 1, E = 2, N = 4, S = 8, F = 16, L = 32, H = 64;
  localparam int SRC = V | E | N;
  localparam logic [31:0] A = 32'h1000, B = 32'h2000, C = 32'h3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] head_i = '0, tail_i = '0, wr_idx = '0, lk_slot = '0;
  logic wr_en = 0, wr_alloc = 0, inv_en = 0, lk_req = 0;
  logic [6:0] wr_status = '0;
  logic [AW-1:0] wr_addr_lo = '0, wr_addr_hi = '0, inv_addr = '0, lk_addr = '0;
  logic lk_done, lk_hit;
  logic [PW-1:0] lk_src;

  always #2 clk = ~clk;

  sb_fwd_match #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_BYTES(LB)) uut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference model
  int m_st[DEPTH], m_lo[DEPTH], m_hi[DEPTH];
  bit m_slo[DEPTH], m_shi[DEPTH];
  bit e_done, e_hit;
  int e_src;

  function automatic int ln(input logic [AW-1:0] a);
    return int'(a / LB);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_st[i] = 0; m_lo[i] = 0; m_hi[i] = 0; m_slo[i] = 0; m_shi[i] = 0;
      end
      e_done = 0; e_hit = 0; e_src = 0;
    end else begin
      e_done = lk_req;
      e_hit  = 0;
      if (lk_req && !(m_st[lk_slot] & E)) begin
        int n;
        n = (int'(tail_i) - int'(head_i) + DEPTH) % DEPTH;
        for (int j = 0; j < n; j++) begin
          int s, q;
          s = (int'(head_i) + j) % DEPTH;
          q = ln(lk_addr);
          if (m_st[s] & V) begin
            if ((m_lo[s] == q && (m_st[s] & L)) || (m_hi[s] == q && (m_st[s] & H))) break;
            if ((m_st[s] & E) && (m_st[s] & N) && !(m_st[s] & S) && !(m_st[s] & F) &&
                ((m_lo[s] == q && !m_slo[s]) || (m_hi[s] == q && !m_shi[s] && m_hi[s] != 0))) begin
              e_hit = 1; e_src = s; break;
            end
          end
        end
      end
      if (inv_en)
        for (int i = 0; i < DEPTH; i++)
          if (m_st[i] & V) begin
            if (m_lo[i] == ln(inv_addr)) m_slo[i] = 1;
            else if (m_hi[i] == ln(inv_addr)) m_shi[i] = 1;
          end
      if (wr_en) begin
        m_st[wr_idx] = int'(wr_status);
        m_lo[wr_idx] = ln(wr_addr_lo);
        m_hi[wr_idx] = ln(wr_addr_hi);
        if (wr_alloc) begin
          m_st[wr_idx] = m_st[wr_idx] & ~(L | H);
          m_slo[wr_idx] = 0; m_shi[wr_idx] = 0;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (lk_done !== e_done || lk_hit !== e_hit || (e_hit && lk_src !== PW'(e_src))) begin
        fails++;
        $display("FAIL %s: done/hit/src actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 tag, lk_done, lk_hit, lk_src, e_done, e_hit, e_src);
      end
    end
  end

  task automatic wr(input int idx, input bit alloc, input int st,
                    input logic [AW-1:0] lo, input logic [AW-1:0] hi);
    wr_en = 1; wr_alloc = alloc; wr_idx = PW'(idx); wr_status = 7'(st);
    wr_addr_lo = lo; wr_addr_hi = hi;
    @(negedge clk);
    wr_en = 0; wr_alloc = 0;
  endtask

  task automatic inv(input logic [AW-1:0] a);
    inv_en = 1; inv_addr = a;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic look(input string t, input int slot, input logic [AW-1:0] a);
    tag = t;
    lk_req = 1; lk_slot = PW'(slot); lk_addr = a;
    @(negedge clk);
    lk_req = 0;
    @(negedge clk);
  endtask

  task automatic win(input int h, input int t);
    head_i = PW'(h); tail_i = PW'(t);
  endtask

  task automatic clear_all();
    for (int i = 0; i < DEPTH; i++) wr(i, 1, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (lk_done !== 0 || lk_hit !== 0) begin
      fails++;
      $display("FAIL R1: done/hit actual %0b/%0b expected 0/0", lk_done, lk_hit);
    end
    win(0, 4);
    look("R1", 2, A);
    win(0, 0);
    look("R1", 0, A);

    // R2 and R3: basic forward with line masking
    win(0, 4);
    wr(1, 1, SRC, A, 0);
    wr(2, 1, V, A + 8, 0);
    look("R2", 2, A + 32'h3C);
    look("R3", 2, A + 32'h17);
    look("R3", 2, A + 32'h40);

    // R5: source eligibility
    wr(1, 0, SRC | S, A, 0); look("R5", 2, A);
    wr(1, 0, SRC | F, A, 0); look("R5", 2, A);
    wr(1, 0, V | E, A, 0);   look("R5", 2, A);
    wr(1, 0, V | N, A, 0);   look("R5", 2, A);
    wr(1, 0, E | N, A, 0);   look("R4", 2, A);

    // R6: halves
    wr(1, 1, SRC, B, A);      look("R6", 2, A);
    wr(1, 1, SRC, C, 0);      look("R6", 2, 32'h0000_0010);
    wr(1, 1, SRC | L, A, B);  wr(1, 0, SRC | L, A, B); look("R6", 2, B);
    wr(1, 1, SRC, A, 0); inv(A); look("R6", 2, A);

    // R7: L1 hit blocks younger source, older source still wins
    clear_all(); wr(2, 1, V, A, 0);
    wr(1, 1, V, A, 0); wr(1, 0, V | L, A, 0);
    wr(3, 1, SRC, A, 0);
    look("R7", 2, A);
    wr(1, 0, V | H, B, A); look("R7", 2, A);
    wr(0, 1, SRC, A, 0); look("R7", 2, A);

    // R8: oldest first, with wrap
    clear_all(); wr(2, 1, V, A, 0);
    wr(1, 1, SRC, A, 0); wr(3, 1, SRC, A, 0);
    look("R8", 2, A);
    win(6, 2);
    wr(7, 1, SRC, A, 0); wr(0, 1, SRC, A, 0); wr(1, 1, V, A, 0);
    look("R8", 1, A);
    wr(7, 0, SRC | S, A, 0); look("R8", 1, A);

    // R4: window limits
    wr(0, 0, SRC | F, A, 0); look("R4", 1, A);
    win(3, 3); look("R4", 1, A);
    win(2, 3); look("R4", 2, A);

    // R9: invalidate
    clear_all(); win(0, 4); wr(2, 1, V, A, 0);
    wr(1, 1, SRC, B, A); inv(A + 4);
    look("R9", 2, A); look("R9", 2, B);
    wr(1, 1, SRC, A, A); inv(A); look("R9", 2, A);
    wr(3, 1, E | N, C, 0); inv(C); wr(3, 0, SRC, C, 0);
    look("R9", 2, C);

    // R10: executed requester
    wr(1, 1, SRC, A, 0); wr(2, 1, V | E, A, 0);
    look("R10", 2, A);
    wr(2, 1, V, A, 0); look("R10", 2, A);

    // R11: allocation clears, plain write keeps
    inv(A); look("R11", 2, A);
    wr(1, 0, SRC, A, 0); look("R11", 2, A);
    wr(1, 1, SRC, A, 0); look("R11", 2, A);
    wr(1, 1, SRC | L, A, 0); look("R11", 2, A);
    inv_en = 1; inv_addr = A; wr(1, 1, SRC, A, 0); inv_en = 0;
    look("R11", 2, A);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule